// File: doc/BRIEF.md
# Bit-Serial Two-Port Wave Filter Adaptor

This block is the arithmetic cell of a bit-serial wave digital filter. Two incident waves arrive as serial two's-complement words on single wires, least significant bit first. A word-start strobe marks the first bit of each word. A signed coefficient sets the reflection factor. The block returns the two reflected waves on two serial output wires, and it raises one overflow flag for each output. Its datapath is one serial subtractor, one serial/parallel multiplier that has one full-adder stage per coefficient bit, and two serial output adders. Every register-to-register path holds at most one full adder and a few gates.

A word occupies a frame of `DATA_W + COEF_W + 2` cycles. The data word has `DATA_W` bits, and the driver sign-extends it to the end of the frame. The extra cycles let the multiplier finish the high part of its product before the next word begins. The product is quantized by dropping its fractional bits, which costs no cycles. A reflected word starts `COEF_W + 1` cycles after its strobe. Each reflected word is defined over `DATA_W + 2` bits, so it carries two guard bits above the data sign. Overflow is reported when the data sign and the two guard bits disagree. Overflow is only flagged and never corrected.

Top module: `wdf_two_port_adaptor`

## Requirements
- R1: With c the signed `COEF_W`-bit coefficient (reflection factor c/16 for the default width), the first output word equals a2 + floor(c·(a2 − a1)/16), taken over its low `DATA_W + 2` bits.
- R2: The second output word equals a1 + floor(c·(a2 − a1)/16), taken over its low `DATA_W + 2` bits.
- R3: Input and output words are LSB first. Output bit k of the word started by a strobe in cycle t appears in cycle t + `COEF_W` + 1 + k.
- R4: The driver repeats the input sign bit up to bit `DATA_W + COEF_W + 1` of the frame. Strobes one frame apart give independent back-to-back words, because every carry restarts at the strobe.
- R5: Quantization truncates toward minus infinity, and adds no cycle to the latency in R3.
- R6: Bit 0 of `ovf` belongs to the first output and bit 1 to the second. Each bit is set when bits `DATA_W-1`, `DATA_W` and `DATA_W+1` of its word are not all equal. It takes its new value in the cycle after bit `DATA_W+1` leaves, and it changes in no other cycle.
- R7: The coefficient is sampled only in the strobe cycle. Values on `coef` in other cycles do not affect the word.
- R8: The strobe period may be longer than a frame. Input bits in the gap cycles after a frame do not affect any output word.
- R9: A synchronous reset clears both serial outputs and both overflow bits.
- R10: A coefficient of zero makes the first output a delayed copy of a2 and the second a delayed copy of a1. A coefficient of −16 makes the first output a delayed copy of a1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_start | input | 1 | High in the cycle that carries bit 0 of both input words |
| a1_bit | input | 1 | Serial incident wave at port 1 |
| a2_bit | input | 1 | Serial incident wave at port 2 |
| coef | input | COEF_W | Signed reflection coefficient, sampled with word_start |
| b1_bit | output | 1 | Serial reflected wave at port 1 |
| b2_bit | output | 1 | Serial reflected wave at port 2 |
| ovf | output | 2 | Per-output overflow flags, bit 0 for b1 |

## Verification
The bound checker checks these properties on every cycle:
- Outputs are quiet after reset.
- An overflow bit changes only in the slot that follows the last guard bit of its word.
- The new overflow value matches the sign and guard bits actually seen on the output wire.
- With a zero coefficient, each output is the opposite input delayed by the fixed latency.

The arithmetic of R1, R2 and R5 needs word-level reference values, so only the bench's scenarios show it, with floor rounding of negative products among them. The same holds for the following, each tested under its own scenario:
- the coefficient being ignored outside the strobe cycle;
- junk in the gap cycles having no effect;
- independence of back-to-back words.

// File: rtl/wdfa_pkg.sv
package wdfa_pkg;

    // Default coefficient width of the adaptor
    localparam int DEF_COEF_W = 5;

    // One full-adder result
    typedef struct packed {
        logic sum;
        logic cy;
    } fa_t;

    // Running state of the guard-bit comparison on one output lane
    typedef struct packed {
        logic ref_bit;   // data sign bit seen on the wire
        logic mism;      // a guard bit differed from it so far
    } ovtrk_t;

    function automatic fa_t full_add(input logic x, input logic y, input logic z);
        fa_t r;
        r.sum = x ^ y ^ z;
        r.cy  = (x & y) | (z & (x ^ y));
        return r;
    endfunction

    // Strobe-to-output delay: one subtractor stage plus the multiplier chain
    function automatic int pipe_lat(input int cw);
        return cw + 1;
    endfunction

endpackage

// File: rtl/wdfa_ser_sub.sv
module wdfa_ser_sub
    import wdfa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic min_bit,
    input  logic sub_bit,
    output logic diff_q
);
    fa_t  r;
    logic cy_q;

    // Subtraction as min + ~sub + 1; the +1 is injected at the word's LSB
    assign r = full_add(min_bit, ~sub_bit, start ? 1'b1 : cy_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            diff_q <= 1'b0;
            cy_q   <= 1'b0;
        end else begin
            diff_q <= r.sum;
            cy_q   <= r.cy;
        end
    end
endmodule

// File: rtl/wdfa_sp_mult.sv
module wdfa_sp_mult
    import wdfa_pkg::*;
#(
    parameter int CW = DEF_COEF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,    // strobe cycle: capture coefficient
    input  logic [CW-1:0] coef,
    input  logic          start,   // cycle carrying bit 0 of x
    input  logic          x,
    output logic          p_bit
);
    logic [CW-1:0] coef_q;
    logic [CW-1:0] s_vec;
    logic [CW-1:0] c_vec;

    always_ff @(posedge clk) begin
        if (rst)       coef_q <= '0;
        else if (load) coef_q <= coef;
    end

    // One full-adder stage per coefficient bit; partial sums move toward stage 0
    for (genvar j = 0; j < CW; j++) begin : g_stage
        logic pp, sin, cin, sq, cq;
        fa_t  r;
        if (j == CW - 1) begin : g_top
            // sign bit of the coefficient has negative weight: add ~pp, +1 at start
            assign pp  = ~(coef_q[j] & x);
            assign sin = 1'b0;
            assign cin = start ? 1'b1 : c_vec[j];
        end else begin : g_low
            assign pp  = coef_q[j] & x;
            assign sin = start ? 1'b0 : s_vec[j+1];
            assign cin = start ? 1'b0 : c_vec[j];
        end
        assign r = full_add(pp, sin, cin);
        always_ff @(posedge clk) begin
            if (rst) begin
                sq <= 1'b0;
                cq <= 1'b0;
            end else begin
                sq <= r.sum;
                cq <= r.cy;
            end
        end
        assign s_vec[j] = sq;
        assign c_vec[j] = cq;
    end

    assign p_bit = s_vec[0];
endmodule

// File: rtl/wdfa_out_lane.sv
module wdfa_out_lane
    import wdfa_pkg::*;
#(
    parameter int DW  = 8,
    parameter int LAT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic out_start,   // cycle of output bit 0
    input  logic a_bit,       // raw incident bit, delayed here
    input  logic q_bit,       // truncated product bit, already aligned
    output logic b_bit,
    output logic ovf
);
    localparam int KMAX = DW + 2;
    localparam int KW   = $clog2(KMAX + 1);

    logic [LAT-1:0] dly_q;
    logic           cy_q;
    logic [KW-1:0]  k_q;
    logic [KW-1:0]  k_cur;
    ovtrk_t         trk_q;
    logic           ovf_q;
    fa_t            add;

    assign add   = full_add(q_bit, dly_q[LAT-1], out_start ? 1'b0 : cy_q);
    assign b_bit = add.sum;
    assign k_cur = out_start ? '0 : k_q;
    assign ovf   = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
            cy_q  <= 1'b0;
            k_q   <= KW'(KMAX);
            trk_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            dly_q <= {dly_q[LAT-2:0], a_bit};
            cy_q  <= add.cy;
            if (k_cur != KW'(KMAX))
                k_q <= k_cur + KW'(1);
            if (k_cur == KW'(DW - 1))
                trk_q <= '{ref_bit: add.sum, mism: 1'b0};
            else if (k_cur == KW'(DW))
                trk_q.mism <= add.sum != trk_q.ref_bit;
            else if (k_cur == KW'(DW + 1))
                ovf_q <= trk_q.mism | (add.sum != trk_q.ref_bit);
        end
    end
endmodule

// File: rtl/wdf_two_port_adaptor.sv
module wdf_two_port_adaptor
    import wdfa_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = DEF_COEF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_start,
    input  logic              a1_bit,
    input  logic              a2_bit,
    input  logic [COEF_W-1:0] coef,
    output logic              b1_bit,
    output logic              b2_bit,
    output logic [1:0]        ovf
);
    localparam int LAT = pipe_lat(COEF_W);

    logic [LAT-1:0] st_q;
    logic           mul_start;
    logic           out_start;
    logic           diff_bit;
    logic           q_bit;
    logic [1:0]     lane_a;
    logic [1:0]     lane_b;

    // Strobe travels with the data: subtractor stage, then multiplier stages
    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= {st_q[LAT-2:0], word_start};
    end
    assign mul_start = st_q[0];
    assign out_start = st_q[LAT-1];

    wdfa_ser_sub u_sub (
        .clk     (clk),
        .rst     (rst),
        .start   (word_start),
        .min_bit (a2_bit),
        .sub_bit (a1_bit),
        .diff_q  (diff_bit)
    );

    wdfa_sp_mult #(.CW(COEF_W)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .load  (word_start),
        .coef  (coef),
        .start (mul_start),
        .x     (diff_bit),
        .p_bit (q_bit)
    );

    // Lane 0 reflects into port 1 (adds a2), lane 1 into port 2 (adds a1)
    assign lane_a = {a1_bit, a2_bit};

    for (genvar l = 0; l < 2; l++) begin : g_lane
        wdfa_out_lane #(.DW(DATA_W), .LAT(LAT)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .out_start (out_start),
            .a_bit     (lane_a[l]),
            .q_bit     (q_bit),
            .b_bit     (lane_b[l]),
            .ovf       (ovf[l])
        );
    end

    assign b1_bit = lane_b[0];
    assign b2_bit = lane_b[1];
endmodule

// File: rtl/wdf_adaptor_chk.sv
module wdf_adaptor_chk #(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          word_start,
    input logic          a1_bit,
    input logic          a2_bit,
    input logic [CW-1:0] coef,
    input logic          b1_bit,
    input logic          b2_bit,
    input logic [1:0]    ovf
);
    localparam int LAT  = CW + 1;
    localparam int OUTW = DW + 2;
    localparam int KIDL = DW + 3;
    localparam int KW   = $clog2(KIDL + 1);

    logic [LAT-1:0] sd_q, a1d_q, a2d_q;
    logic [KW-1:0]  k_q, kpos;
    logic           ost, cz_q, czo_q, cz_eff, in_word;
    logic [1:0]     bvec, ref_q, mis_q;

    assign ost     = sd_q[LAT-1];
    assign kpos    = ost ? '0 : k_q;
    assign cz_eff  = ost ? cz_q : czo_q;
    assign in_word = kpos < KW'(OUTW);
    assign bvec    = {b2_bit, b1_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_q <= '0; a1d_q <= '0; a2d_q <= '0;
            k_q <= KW'(KIDL); cz_q <= 1'b0; czo_q <= 1'b0;
            ref_q <= '0; mis_q <= '0;
        end else begin
            sd_q  <= {sd_q[LAT-2:0], word_start};
            a1d_q <= {a1d_q[LAT-2:0], a1_bit};
            a2d_q <= {a2d_q[LAT-2:0], a2_bit};
            if (word_start) cz_q <= (coef == '0);
            if (ost) czo_q <= cz_q;
            if (kpos != KW'(KIDL)) k_q <= kpos + KW'(1);
            if (kpos == KW'(DW - 1)) begin
                ref_q <= bvec;
                mis_q <= '0;
            end else if (kpos == KW'(DW) || kpos == KW'(DW + 1)) begin
                mis_q <= mis_q | (bvec ^ ref_q);
            end
        end
    end

    // R9: reset leaves both outputs and both flags low
    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (ovf == 2'b00 && !b1_bit && !b2_bit));

    // R6: flags move only in the slot after the last guard bit
    a_r6_ovf_slot: assert property (@(posedge clk) disable iff (rst)
        !$stable(ovf) |-> (kpos == KW'(DW + 2)));

    // R6: new flag value matches sign and guard bits seen on the wires
    a_r6_ovf_value: assert property (@(posedge clk) disable iff (rst)
        (kpos == KW'(DW + 2)) |-> (ovf == mis_q));

    // R10: zero coefficient gives crossed, delayed inputs
    a_r10_zero_b1: assert property (@(posedge clk) disable iff (rst)
        (in_word && cz_eff) |-> (b1_bit == a2d_q[LAT-1]));

    a_r10_zero_b2: assert property (@(posedge clk) disable iff (rst)
        (in_word && cz_eff) |-> (b2_bit == a1d_q[LAT-1]));
endmodule

bind wdf_two_port_adaptor wdf_adaptor_chk #(.DW(DATA_W), .CW(COEF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_start (word_start),
    .a1_bit     (a1_bit),
    .a2_bit     (a2_bit),
    .coef       (coef),
    .b1_bit     (b1_bit),
    .b2_bit     (b2_bit),
    .ovf        (ovf)
);

// File: tb/sim_wdf_two_port_adaptor.sv
`timescale 1ns/1ps
module sim_wdf_two_port_adaptor;
    localparam int DW    = 8;
    localparam int CW    = 5;
    localparam int F     = DW + CW + 2;
    localparam int LAT   = CW + 1;
    localparam int OUT_W = DW + 2;
    localparam int NMAX  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          word_start = 1'b0;
    logic          a1_bit = 1'b0;
    logic          a2_bit = 1'b0;
    logic [CW-1:0] coef = '0;
    logic          b1_bit, b2_bit;
    logic [1:0]    ovf;

    int checks = 0;
    int errors = 0;

    int wa1 [NMAX];
    int wa2 [NMAX];
    int wc  [NMAX];
    int e1  [NMAX];
    int e2  [NMAX];
    logic [1:0] eo [NMAX];
    logic [OUT_W-1:0] g1 [NMAX];
    logic [OUT_W-1:0] g2 [NMAX];

    always #2 clk = ~clk;

    wdf_two_port_adaptor #(.DATA_W(DW), .COEF_W(CW)) u0 (
        .clk(clk), .rst(rst), .word_start(word_start),
        .a1_bit(a1_bit), .a2_bit(a2_bit), .coef(coef),
        .b1_bit(b1_bit), .b2_bit(b2_bit), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic not_fit(input int v);
        return (v < -(1 << (DW - 1))) || (v > (1 << (DW - 1)) - 1);
    endfunction

    // Streams nw words with a given gap, collects both outputs, checks them
    task automatic play(input int nw, input int gap, input bit junk, input string tag);
        int per = F + gap;
        int total = nw * per + LAT + DW + 3;
        for (int w = 0; w < nw; w++) begin
            int q = (wc[w] * (wa2[w] - wa1[w])) >>> (CW - 1);
            e1[w] = wa2[w] + q;
            e2[w] = wa1[w] + q;
            eo[w] = {not_fit(e2[w]), not_fit(e1[w])};
        end
        for (int n = 0; n < total; n++) begin
            @(negedge clk);
            if (n >= LAT) begin
                int m = n - LAT;
                int w = m / per;
                int k = m % per;
                if (w < nw && k < OUT_W) begin
                    g1[w][k] = b1_bit;
                    g2[w][k] = b2_bit;
                end
                if (w < nw && k == DW + 2)
                    chk(ovf == eo[w], {tag, " R6 ovf update"}, int'(ovf), int'(eo[w]));
                if (w >= 1 && w <= nw && k == DW + 1)
                    chk(ovf == eo[w-1], {tag, " R6 ovf held"}, int'(ovf), int'(eo[w-1]));
            end
            begin
                int w = n / per;
                int k = n % per;
                if (w < nw) begin
                    word_start = (k == 0);
                    if (k < F) begin
                        a1_bit = 1'((wa1[w] >>> k) & 1);
                        a2_bit = 1'((wa2[w] >>> k) & 1);
                    end else begin
                        a1_bit = 1'($urandom);
                        a2_bit = 1'($urandom);
                    end
                    if (k == 0 || !junk) coef = CW'(wc[w]);
                    else                 coef = CW'($urandom);
                end else begin
                    word_start = 1'b0;
                    a1_bit = 1'b0;
                    a2_bit = 1'b0;
                    coef = '0;
                end
            end
        end
        for (int w = 0; w < nw; w++) begin
            logic [OUT_W-1:0] x1 = OUT_W'(e1[w]);
            logic [OUT_W-1:0] x2 = OUT_W'(e2[w]);
            chk(g1[w] == x1, {tag, " R1 R3 b1 word"}, int'(g1[w]), int'(x1));
            chk(g2[w] == x2, {tag, " R2 R3 b2 word"}, int'(g2[w]), int'(x2));
        end
    endtask

    task automatic set_w(input int i, input int a1, input int a2, input int c);
        wa1[i] = a1; wa2[i] = a2; wc[i] = c;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(b1_bit == 1'b0, "R9 b1 in reset", int'(b1_bit), 0);
        chk(b2_bit == 1'b0, "R9 b2 in reset", int'(b2_bit), 0);
        chk(ovf == 2'b00, "R9 ovf in reset", int'(ovf), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ovf == 2'b00 && !b1_bit && !b2_bit, "R9 after release", int'(ovf), 0);
    endtask

    task automatic t_basic;
        set_w(0, 10, 20, 5);
        set_w(1, -7, 3, 7);
        set_w(2, 50, -20, -3);
        set_w(3, -1, -1, 9);
        set_w(4, 1, 0, 1);      // R5: -1/16 must floor to -1
        set_w(5, 0, 1, -1);     // R5: -1/16 again, other sign of d
        play(6, 0, 1'b0, "basic R5");
    endtask

    task automatic t_coef_edges;
        set_w(0, 33, -90, 0);   // R10 crossing
        set_w(1, 40, -60, -16); // R10 b1 = a1
        set_w(2, -128, 5, 0);
        play(3, 0, 1'b0, "edges R10");
    endtask

    task automatic t_overflow;
        set_w(0, -128, 127, 15);
        set_w(1, 127, -128, 15);
        set_w(2, 100, 100, -16);
        set_w(3, -128, 127, -16);
        set_w(4, 60, 60, 3);
        play(5, 0, 1'b0, "ovf R6");
    endtask

    task automatic t_junk_coef;
        set_w(0, 25, -40, 6);
        set_w(1, -90, 70, -11);
        set_w(2, 12, 13, 15);
        play(3, 0, 1'b1, "coef R7");
    endtask

    task automatic t_gap;
        set_w(0, 77, -3, 4);
        set_w(1, -64, 64, -8);
        set_w(2, 5, -125, 13);
        play(3, 3, 1'b1, "gap R8");
    endtask

    task automatic t_stream;
        for (int i = 0; i < 12; i++)
            set_w(i, int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
                  int'($urandom_range(31)) - 16);
        play(12, 0, 1'b0, "stream R4");
    endtask

    initial begin
        t_reset;
        t_basic;
        t_coef_edges;
        t_overflow;
        t_junk_coef;
        t_gap;
        t_stream;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4ns * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule